// File: doc/BRIEF.md
# Serial Audio Frame Transmitter and Receiver

This block produces the serial audio timing of a sound processor. A free-running frame counter divides the master clock into frames of 1024 master clocks. Each frame holds 64 bit-clock periods of 16 master clocks each, split into a left slot and a right slot of 32 bits. Two serial outputs share one bit clock and one word-select line and together carry four channels. A single serial input returns one stereo pair.

Once per frame the block raises a one-cycle strobe. On that cycle it takes in four parallel samples, the alignment mode and the sample-width code, and it moves the two 16-bit words captured during the ending frame to its parallel outputs. Samples are 20 bits wide and aligned to the MSB. The width code sets how many of their upper bits are sent. Alignment is I2S, where the MSB comes one bit clock after the word-select edge, or left-justified, where the MSB starts at that edge.

Top module: `audio_frame_serdes`

## Requirements
- R1: `frame_strobe` is high for exactly one master clock every 1024 master clocks. The first pulse comes on the 1023rd clock edge after reset is released.
- R2: `bclk` has a period of 16 master clocks. It is low for 8 clocks and high for 8 clocks. It falls on the first cycle of every frame, and bit n of the frame starts on the n-th falling edge (n = 0..63).
- R3: `wsel` is low for the left word and high for the right word. With `mode_lj`=1 it changes at the start of frame bits 0 and 32. With `mode_lj`=0 (I2S) it changes one bit earlier, at bits 63 and 31. It changes only where `bclk` falls.
- R4: Each output sends its word MSB first and changes only where `bclk` falls, so it holds steady across each rising edge. With `mode_lj`=1 the MSB is at slot bit 0. With `mode_lj`=0 it is at slot bit 1, and slot bit 0 is zero.
- R5: `width_code` 0, 1 and 2 send the upper 16, 18 and 20 bits of the 20-bit sample. Code 3 sends 20 bits. Every later bit of the 32-bit slot is zero.
- R6: `sdo0` carries `tx0_left`/`tx0_right` and `sdo1` carries `tx1_left`/`tx1_right`. Both use the same timing, and their content is independent.
- R7: Samples, `mode_lj` and `width_code` are taken only on the `frame_strobe` cycle and govern the whole next frame. Changes at any other time do not affect the frame in progress.
- R8: `sdi` is sampled at each `bclk` rising edge. It uses the same slot alignment as the outputs, so the 16-bit word starts at slot bit 0 (left-justified) or slot bit 1 (I2S). Bits outside that 16-bit word are ignored. The words captured in a frame appear on `rx_left`/`rx_right` from the cycle after its strobe and stay unchanged until the next strobe.
- R9: After reset, `bclk`, `wsel`, `sdo0`, `sdo1`, `frame_strobe`, `rx_left` and `rx_right` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lj | input | 1 | 1 selects left-justified, 0 selects I2S; taken at strobe |
| width_code | input | 2 | Sent sample width: 0=16, 1=18, 2/3=20 bits |
| tx0_left | input | 20 | Left sample for line 0 |
| tx0_right | input | 20 | Right sample for line 0 |
| tx1_left | input | 20 | Left sample for line 1 |
| tx1_right | input | 20 | Right sample for line 1 |
| sdi | input | 1 | Serial audio input |
| frame_strobe | output | 1 | One-cycle frame boundary pulse |
| rx_left | output | 16 | Left word captured in the previous frame |
| rx_right | output | 16 | Right word captured in the previous frame |
| bclk | output | 1 | Bit clock |
| wsel | output | 1 | Word select |
| sdo0 | output | 1 | Serial output line 0 |
| sdo1 | output | 1 | Serial output line 1 |

## Verification
The strobe cycle does three things at once. It latches new samples and configuration, it hands the captured input words to the parallel outputs, and it ends the last right-slot bit of the old frame. In I2S mode, word select has already moved to the next left word by then. The bench changes every parallel input and the mode one cycle after a strobe. It then checks that the frame in progress still follows the old settings, that the next frame follows the new ones, and that the received words seen on the first cycle of a frame are the ones driven during the previous frame.

// File: rtl/audio_frame_serdes.sv
module audio_frame_serdes #(
  parameter int CLK_PER_BIT = 16,
  parameter int SLOT_BITS   = 32,
  parameter int TX_W        = 20,
  parameter int RX_W        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_lj,
  input  logic [1:0]      width_code,
  input  logic [TX_W-1:0] tx0_left,
  input  logic [TX_W-1:0] tx0_right,
  input  logic [TX_W-1:0] tx1_left,
  input  logic [TX_W-1:0] tx1_right,
  input  logic            sdi,
  output logic            frame_strobe,
  output logic [RX_W-1:0] rx_left,
  output logic [RX_W-1:0] rx_right,
  output logic            bclk,
  output logic            wsel,
  output logic            sdo0,
  output logic            sdo1
);

  localparam int BIT_LG  = $clog2(CLK_PER_BIT);
  localparam int SLOT_LG = $clog2(SLOT_BITS);
  localparam int CNT_W   = BIT_LG + SLOT_LG + 1;
  localparam logic [SLOT_LG:0]  N_HI    = (SLOT_LG+1)'(TX_W);
  localparam logic [SLOT_LG:0]  N_MID   = (SLOT_LG+1)'(TX_W - 2);
  localparam logic [SLOT_LG:0]  N_LO    = (SLOT_LG+1)'(TX_W - 4);
  localparam logic [SLOT_LG:0]  RX_N    = (SLOT_LG+1)'(RX_W);
  localparam logic [BIT_LG-1:0] RISE_PH = BIT_LG'(CLK_PER_BIT/2 - 1);

  logic [CNT_W-1:0] cnt;
  logic             lj_q;
  logic [1:0]       wc_q;
  logic [TX_W-1:0]  h0l, h0r, h1l, h1r;
  logic [RX_W-1:0]  cap_l, cap_r;

  wire [SLOT_LG:0]   bitn     = cnt[CNT_W-1:BIT_LG];
  wire [SLOT_LG:0]   bitn_nx  = bitn + 1'b1;
  wire               right    = bitn[SLOT_LG];
  wire [SLOT_LG-1:0] slot_bit = bitn[SLOT_LG-1:0];
  wire               lead     = ~lj_q & (slot_bit == '0);
  wire [SLOT_LG-1:0] pos      = slot_bit - {{(SLOT_LG-1){1'b0}}, ~lj_q};
  wire [SLOT_LG:0]   nbits    = (wc_q == 2'd0) ? N_LO : (wc_q == 2'd1) ? N_MID : N_HI;
  wire               tx_on    = ~lead & ({1'b0, pos} < nbits);
  wire               rx_on    = ~lead & ({1'b0, pos} < RX_N);
  wire [TX_W-1:0]    sh0      = (right ? h0r : h0l) << pos;
  wire [TX_W-1:0]    sh1      = (right ? h1r : h1l) << pos;

  assign frame_strobe = &cnt;
  assign bclk         = cnt[BIT_LG-1];
  assign wsel         = lj_q ? right : bitn_nx[SLOT_LG];
  assign sdo0         = tx_on & sh0[TX_W-1];
  assign sdo1         = tx_on & sh1[TX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      lj_q     <= 1'b0;
      wc_q     <= 2'd0;
      h0l      <= '0;
      h0r      <= '0;
      h1l      <= '0;
      h1r      <= '0;
      cap_l    <= '0;
      cap_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (frame_strobe) begin
        lj_q     <= mode_lj;
        wc_q     <= width_code;
        h0l      <= tx0_left;
        h0r      <= tx0_right;
        h1l      <= tx1_left;
        h1r      <= tx1_right;
        rx_left  <= cap_l;
        rx_right <= cap_r;
      end
      if (cnt[BIT_LG-1:0] == RISE_PH && rx_on) begin
        for (int i = 0; i < RX_W; i++) begin
          if (pos == SLOT_LG'(i)) begin
            if (right) cap_r[RX_W-1-i] <= sdi;
            else       cap_l[RX_W-1-i] <= sdi;
          end
        end
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);  // R1
  AST_BCLK_FALLS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_strobe) |-> $fell(bclk));  // R2
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wsel) |-> $fell(bclk));  // R3
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && $past(bclk)) |-> ($stable(sdo0) && $stable(sdo1)));  // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_strobe) |-> ($stable(rx_left) && $stable(rx_right)));  // R8

endmodule

// File: tb/audio_frame_serdes_tb_top.sv
module audio_frame_serdes_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_lj = 1'b0;
  logic [1:0] width_code = 2'd0;
  logic [19:0] tx0_left = '0, tx0_right = '0, tx1_left = '0, tx1_right = '0;
  logic sdi = 1'b0;
  logic frame_strobe, bclk, wsel, sdo0, sdo1;
  logic [15:0] rx_left, rx_right;

  int checks = 0;
  int fails = 0;
  logic [15:0] prev_il = '0, prev_ir = '0;
  bit have_prev = 0;

  always #2.5 clk = ~clk;

  audio_frame_serdes dut_i (
    .clk(clk), .rst_n(rst_n), .mode_lj(mode_lj), .width_code(width_code),
    .tx0_left(tx0_left), .tx0_right(tx0_right), .tx1_left(tx1_left), .tx1_right(tx1_right),
    .sdi(sdi), .frame_strobe(frame_strobe), .rx_left(rx_left), .rx_right(rx_right),
    .bclk(bclk), .wsel(wsel), .sdo0(sdo0), .sdo1(sdo1));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int slot_pos(input bit lj, input int b);
    return (b % 32) - (lj ? 0 : 1);
  endfunction

  function automatic bit exp_tx(input bit lj, input logic [1:0] wc, input logic [19:0] l,
                                input logic [19:0] r, input int b);
    int p = slot_pos(lj, b);
    int n = (wc == 2'd0) ? 16 : (wc == 2'd1) ? 18 : 20;
    logic [19:0] s = (b >= 32) ? r : l;
    if (p < 0 || p >= n) return 1'b0;
    return s[19-p];
  endfunction

  function automatic bit exp_ws(input bit lj, input int b);
    if (lj) return b >= 32;
    return ((b + 1) % 64) >= 32;
  endfunction

  // Entered at the negedge where the strobe is high; ends at the next strobe negedge.
  task automatic do_frame(input bit lj, input logic [1:0] wc,
                          input logic [19:0] a0l, input logic [19:0] a0r,
                          input logic [19:0] a1l, input logic [19:0] a1r,
                          input logic [15:0] il, input logic [15:0] ir, input bit scramble);
    mode_lj = lj; width_code = wc;
    tx0_left = a0l; tx0_right = a0r; tx1_left = a1l; tx1_right = a1r;
    for (int k = 0; k < 1024; k++) begin
      int b = k / 16;
      int ph = k % 16;
      @(negedge clk);
      if (k == 0 && have_prev) begin
        chk("R8", "rx_left after strobe", rx_left, prev_il);
        chk("R8", "rx_right after strobe", rx_right, prev_ir);
      end
      if (k == 600 && have_prev) chk("R8", "rx_left held", rx_left, prev_il);
      if (k == 1 && scramble) begin
        // R7: late changes must not reach this frame
        mode_lj = ~lj; width_code = 2'd0;
        tx0_left = ~a0l; tx0_right = ~a0r; tx1_left = ~a1l; tx1_right = ~a1r;
      end
      if (ph == 0) begin
        int p = slot_pos(lj, b);
        logic [15:0] w = (b >= 32) ? ir : il;
        sdi = (p >= 0 && p < 16) ? w[15-p] : b[0] ^ b[2];
        chk("R2", "bclk low half", bclk, 0);
      end
      if (ph == 8) chk("R2", "bclk high half", bclk, 1);
      if (ph == 4 || ph == 12) chk("R3", "wsel", wsel, exp_ws(lj, b));
      if (ph == 12) begin
        chk(wc == 2'd2 ? "R4" : "R5", "sdo0", sdo0, exp_tx(lj, wc, a0l, a0r, b));
        chk("R6", "sdo1", sdo1, exp_tx(lj, wc, a1l, a1r, b));
      end
      if (k == 512) chk("R1", "strobe mid frame", frame_strobe, 0);
      if (k == 1023) chk("R1", "strobe at frame end", frame_strobe, 1);
    end
    prev_il = il; prev_ir = ir; have_prev = 1;
  endtask

  task automatic t_reset;
    int n = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9", "bclk", bclk, 0);
    chk("R9", "wsel", wsel, 0);
    chk("R9", "sdo0", sdo0, 0);
    chk("R9", "sdo1", sdo1, 0);
    chk("R9", "strobe", frame_strobe, 0);
    chk("R9", "rx", {rx_left, rx_right}, 0);
    while (!frame_strobe && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R1", "cycles to first strobe", n, 1023);
  endtask

  task automatic t_left_justified;
    do_frame(1'b1, 2'd2, 20'hA5F3C, 20'h6B1D9, 20'h1248E, 20'hFEDC1, 16'hA5C3, 16'h3C96, 1'b0);
    do_frame(1'b1, 2'd3, 20'h80001, 20'h7FFFE, 20'hC3C3C, 20'h0F0F1, 16'h8001, 16'h7FFE, 1'b0);
  endtask

  task automatic t_i2s_widths;
    do_frame(1'b0, 2'd0, 20'hFFFFF, 20'hABCDE, 20'h13579, 20'hFFFFF, 16'h1234, 16'hFEDC, 1'b0);
    do_frame(1'b0, 2'd1, 20'hFFFFF, 20'h5A5A5, 20'h00003, 20'hFFFFF, 16'hFFFF, 16'h0001, 1'b0);
  endtask

  task automatic t_late_change;
    do_frame(1'b0, 2'd2, 20'h9C3A7, 20'h2E4F1, 20'h71B0D, 20'hC0FFE, 16'h5AA5, 16'hC33C, 1'b1);
    do_frame(1'b1, 2'd1, 20'h3FFFF, 20'hE0007, 20'h55555, 20'hAAAAA, 16'h0F0F, 16'hF0F0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_left_justified();
    t_i2s_widths();
    t_late_change();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule